// File: doc/BRIEF.md
# Trace Power-Down Lock Controller

This block controls register access to a trace unit whose core power domain can be switched off. It sits on a simple single-cycle register bus and decides, access by access, whether a trace configuration register may be read or written. While an operating-system lock or a sticky power-loss flag is set, such accesses end in a bus error. Software can always reach the lock and status registers, so it can always clear the condition that blocks it.

Before power is removed, software reads the power status register to clear the sticky flag. It then sets the lock with a key write and reads the whole configuration bank out through one auto-incrementing save/restore register. After power returns, it clears the sticky flag, sets the lock, writes the bank back through the same register, and releases the lock. A power-up event input marks that the core domain lost its state. A parameter selects a full variant or a single-power variant. The single-power variant has no lock and no save/restore path, and its status registers read as constants.

Every access gets its response (valid, error, read data) registered one clock after the request.

Top module: `trace_pd_gate`

## Requirements
- R1: After reset the lock is clear, the sticky flag is set in the full variant, and each bank register i holds 0xA0000000 + i. Trace registers sit at word addresses 0 to DEPTH-1.
- R2: In the full variant a read of the lock status register (address 0x41) returns bit 0 = 1, bit 3 = 0, bit 1 = current lock state, and all other bits 0.
- R3: In the single-power variant the lock status register reads 0 and the power status register (0x45) reads 0x00000001. Writes to the lock access register (0x40) have no effect. Trace accesses never error. Any save/restore access (0x42) errors.
- R4: In the full variant, writing 0xC5ACCE55 to the lock access register sets the lock, and writing any other value clears it.
- R5: In the full variant, a trace register access made while the lock or the sticky flag is set returns an error and read data 0, and leaves the register unchanged.
- R6: A read of the power status register returns bit 0 = 1, bit 1 = sticky flag, all other bits 0, and clears the sticky flag.
- R7: A power-up event sets the sticky flag and returns every bank register to its reset value. It takes priority over a power-status read or a bank write in the same cycle.
- R8: Setting the lock resets the save/restore pointer. The first save/restore read then returns DEPTH, and the following reads return bank registers 0, 1, … in order.
- R9: After the lock is set, the first save/restore write is discarded and the following writes load bank registers 0, 1, … in order.
- R10: A save/restore access while the lock is clear returns an error and does not move the pointer.
- R11: Accesses to the lock access, lock status and power status registers never return an error.
- R12: Each request produces exactly one response cycle, one clock later. Idle cycles produce no response.
- R13: Once the whole bank has been transferred, further save/restore reads return 0 and further writes change nothing. Unmapped addresses read 0 without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Write data |
| pwr_evt | input | 1 | Core domain powered up after losing state |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access ended with error |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench builds two instances. One uses the full variant with a four-register bank, which makes the save and restore sequences, pointer overrun past the bank end, and the clash between a power event and a status read reachable. The other uses the single-power variant with a three-register bank, where the constant status values, the ignored key write and the refused save/restore access are observed. A behavioural model tracks the lock, the sticky flag, the pointer and the bank for both instances, and every response cycle is compared against it.

// File: rtl/trace_pd_pkg.sv
package trace_pd_pkg;
    localparam int          ADDR_W      = 8;
    localparam int          DATA_W      = 32;
    localparam logic [31:0] UNLOCK_KEY  = 32'hC5AC_CE55;
    localparam logic [31:0] BANK_BASE   = 32'hA000_0000;

    localparam logic [ADDR_W-1:0] A_LOCK_ACC  = 8'h40;
    localparam logic [ADDR_W-1:0] A_LOCK_STAT = 8'h41;
    localparam logic [ADDR_W-1:0] A_SAVE_RST  = 8'h42;
    localparam logic [ADDR_W-1:0] A_PD_STAT   = 8'h45;

    typedef enum logic [2:0] {
        RG_TRACE,
        RG_LOCK_ACC,
        RG_LOCK_STAT,
        RG_SAVE_RST,
        RG_PD_STAT,
        RG_NONE
    } region_e;

    typedef struct packed {
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    function automatic logic [DATA_W-1:0] bank_default(input int idx);
        return BANK_BASE + DATA_W'(idx);
    endfunction
endpackage

// File: rtl/trace_pd_decode.sv
module trace_pd_decode
    import trace_pd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    always_comb begin
        if (addr < ADDR_W'(DEPTH)) begin
            region = RG_TRACE;
        end else begin
            unique case (addr)
                A_LOCK_ACC:  region = RG_LOCK_ACC;
                A_LOCK_STAT: region = RG_LOCK_STAT;
                A_SAVE_RST:  region = RG_SAVE_RST;
                A_PD_STAT:   region = RG_PD_STAT;
                default:     region = RG_NONE;
            endcase
        end
    end
endmodule

// File: rtl/trace_pd_bank.sv
module trace_pd_bank
    import trace_pd_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_defaults,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [DEPTH-1:0][DATA_W-1:0] regs
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        logic [DATA_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (load_defaults) begin
                val_d = bank_default(i);
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                val_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= bank_default(i);
            end else begin
                val_q <= val_d;
            end
        end

        assign regs[i] = val_q;
    end
endmodule

// File: rtl/trace_pd_lock.sv
module trace_pd_lock #(
    parameter bit FULL_PD = 1'b1,
    parameter int PTR_W   = 3,
    parameter int PTR_MAX = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_wr,
    input  logic             key_ok,
    input  logic             pd_rd,
    input  logic             pwr_evt,
    input  logic             sr_step,
    output logic             lock_q,
    output logic             sticky_q,
    output logic [PTR_W-1:0] ptr_q
);
    typedef struct packed {
        logic             lock;
        logic             sticky;
        logic [PTR_W-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (FULL_PD) begin
            if (key_wr) begin
                st_d.lock = key_ok;
            end
            if (key_wr && key_ok) begin
                st_d.ptr = '0;
            end else if (sr_step && (st_q.ptr != PTR_W'(PTR_MAX))) begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
            if (pwr_evt) begin
                st_d.sticky = 1'b1;
            end else if (pd_rd) begin
                st_d.sticky = 1'b0;
            end
        end else begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lock   <= 1'b0;
            st_q.sticky <= FULL_PD;
            st_q.ptr    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_q   = st_q.lock;
    assign sticky_q = st_q.sticky;
    assign ptr_q    = st_q.ptr;
endmodule

// File: rtl/trace_pd_gate.sv
module trace_pd_gate
    import trace_pd_pkg::*;
#(
    parameter bit FULL_PD = 1'b1,
    parameter int DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              pwr_evt,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata
);
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PTR_MAX = DEPTH + 1;
    localparam int PTR_W   = $clog2(PTR_MAX + 1);

    region_e                      region;
    logic                         lock_state;
    logic                         sticky_state;
    logic [PTR_W-1:0]             sr_ptr;
    logic [DEPTH-1:0][DATA_W-1:0] bank_regs;

    logic              key_wr, pd_rd, sr_step;
    logic              bank_we;
    logic [IDX_W-1:0]  bank_widx;
    logic [IDX_W-1:0]  trace_idx;
    logic [IDX_W-1:0]  sr_idx;
    logic              sr_in_bank;
    logic              trace_blocked;
    logic              sr_open;
    rsp_t              rsp_d, rsp_q;

    trace_pd_decode #(.DEPTH(DEPTH)) u_dec (
        .addr   (req_addr),
        .region (region)
    );

    trace_pd_lock #(.FULL_PD(FULL_PD), .PTR_W(PTR_W), .PTR_MAX(PTR_MAX)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_ok   (req_wdata == UNLOCK_KEY),
        .pd_rd    (pd_rd),
        .pwr_evt  (pwr_evt),
        .sr_step  (sr_step),
        .lock_q   (lock_state),
        .sticky_q (sticky_state),
        .ptr_q    (sr_ptr)
    );

    trace_pd_bank #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_defaults (pwr_evt),
        .wr_en         (bank_we),
        .wr_idx        (bank_widx),
        .wr_data       (req_wdata),
        .regs          (bank_regs)
    );

    assign trace_idx     = req_addr[IDX_W-1:0];
    assign sr_in_bank    = (sr_ptr != '0) && (sr_ptr <= PTR_W'(DEPTH));
    assign sr_idx        = IDX_W'(sr_ptr - 1'b1);
    assign trace_blocked = FULL_PD && (lock_state || sticky_state);
    assign sr_open       = FULL_PD && lock_state;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        key_wr      = 1'b0;
        pd_rd       = 1'b0;
        sr_step     = 1'b0;
        bank_we     = 1'b0;
        bank_widx   = trace_idx;
        if (req_valid) begin
            unique case (region)
                RG_TRACE: begin
                    if (trace_blocked) begin
                        rsp_d.err = 1'b1;
                    end else if (req_write) begin
                        bank_we = 1'b1;
                    end else begin
                        rsp_d.rdata = bank_regs[trace_idx];
                    end
                end
                RG_LOCK_ACC: begin
                    key_wr = FULL_PD && req_write;
                end
                RG_LOCK_STAT: begin
                    if (FULL_PD && !req_write) begin
                        rsp_d.rdata = {28'd0, 1'b0, 1'b0, lock_state, 1'b1};
                    end
                end
                RG_SAVE_RST: begin
                    if (!sr_open) begin
                        rsp_d.err = 1'b1;
                    end else begin
                        sr_step = 1'b1;
                        if (req_write) begin
                            bank_we   = sr_in_bank;
                            bank_widx = sr_idx;
                        end else if (sr_ptr == '0) begin
                            rsp_d.rdata = DATA_W'(DEPTH);
                        end else if (sr_in_bank) begin
                            rsp_d.rdata = bank_regs[sr_idx];
                        end
                    end
                end
                RG_PD_STAT: begin
                    if (!req_write) begin
                        pd_rd       = 1'b1;
                        rsp_d.rdata = {30'd0, sticky_state, 1'b1};
                    end
                end
                default: begin
                    rsp_d.rdata = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;
endmodule

// File: rtl/trace_pd_gate_chk.sv
module trace_pd_gate_chk #(
    parameter bit FULL_PD = 1'b1,
    parameter int DEPTH   = 4,
    parameter int PTR_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [7:0]       req_addr,
    input logic [31:0]      req_wdata,
    input logic             pwr_evt,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [31:0]      rsp_rdata,
    input logic             lock_state,
    input logic             sticky_state,
    input logic [PTR_W-1:0] sr_ptr
);
    logic rd_lstat, wr_lacc, to_trace, to_sr, to_ctrl, rd_pd;
    assign rd_lstat = req_valid && !req_write && (req_addr == 8'h41);
    assign wr_lacc  = req_valid && req_write && (req_addr == 8'h40);
    assign to_trace = req_valid && (req_addr < 8'(DEPTH));
    assign to_sr    = req_valid && (req_addr == 8'h42);
    assign rd_pd    = req_valid && !req_write && (req_addr == 8'h45);
    assign to_ctrl  = req_valid && ((req_addr == 8'h40) || (req_addr == 8'h41) || (req_addr == 8'h45));

    a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r2_lstat_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (FULL_PD && rd_lstat) |=> (rsp_rdata[0] && !rsp_rdata[3]));
    a_r3_single_lstat_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!FULL_PD && rd_lstat) |=> (rsp_rdata == 32'd0));
    a_r4_other_value_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        (FULL_PD && wr_lacc && (req_wdata != 32'hC5AC_CE55)) |=> !lock_state);
    a_r5_trace_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (FULL_PD && to_trace && (lock_state || sticky_state)) |=> rsp_err);
    a_r6_sticky_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pd && !pwr_evt) |=> !sticky_state);
    a_r7_event_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (FULL_PD && pwr_evt) |=> sticky_state);
    a_r8_ptr_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        (FULL_PD && wr_lacc && (req_wdata == 32'hC5AC_CE55)) |=> (lock_state && (sr_ptr == '0)));
    a_r10_sr_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (to_sr && !lock_state) |=> (rsp_err && $stable(sr_ptr)));
    a_r11_ctrl_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        to_ctrl |=> !rsp_err);
endmodule

bind trace_pd_gate trace_pd_gate_chk #(
    .FULL_PD (FULL_PD),
    .DEPTH   (DEPTH),
    .PTR_W   (PTR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .pwr_evt      (pwr_evt),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_rdata    (rsp_rdata),
    .lock_state   (lock_state),
    .sticky_state (sticky_state),
    .sr_ptr       (sr_ptr)
);

// File: tb/tb_trace_pd_gate.sv
module tb_trace_pd_gate;
    localparam int CLK_P = 10;
    localparam int FD    = 4;
    localparam int SD    = 3;
    localparam logic [31:0] KEY = 32'hC5AC_CE55;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic        vf = 1'b0, vs = 1'b0, wr = 1'b0, evt_f = 1'b0, evt_s = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        f_v, f_e, s_v, s_e;
    logic [31:0] f_d, s_d;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int          m_lock[2];
    int          m_sticky[2];
    int          m_ptr[2];
    logic [31:0] m_bank[2][FD];

    always #(CLK_P/2) clk = ~clk;

    trace_pd_gate #(.FULL_PD(1'b1), .DEPTH(FD)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(vf), .req_write(wr), .req_addr(addr),
        .req_wdata(wdata), .pwr_evt(evt_f), .rsp_valid(f_v), .rsp_err(f_e), .rsp_rdata(f_d)
    );

    trace_pd_gate #(.FULL_PD(1'b0), .DEPTH(SD)) dut_single (
        .clk(clk), .rst_n(rst_n), .req_valid(vs), .req_write(wr), .req_addr(addr),
        .req_wdata(wdata), .pwr_evt(evt_s), .rsp_valid(s_v), .rsp_err(s_e), .rsp_rdata(s_d)
    );

    task automatic model_reset();
        for (int s = 0; s < 2; s++) begin
            m_lock[s] = 0;
            m_sticky[s] = (s == 0) ? 1 : 0;
            m_ptr[s] = 0;
            for (int i = 0; i < FD; i++) m_bank[s][i] = 32'hA000_0000 + i;
        end
    endtask

    // Behavioural reference of one cycle for instance s (0 = full, 1 = single)
    task automatic model_step(input int s, input bit v, input bit w, input int a,
                              input logic [31:0] d, input bit ev,
                              output bit ee, output logic [31:0] ed);
        int depth = (s == 0) ? FD : SD;
        bit full = (s == 0);
        ee = 1'b0;
        ed = '0;
        if (v) begin
            if (a < depth) begin
                if (full && (m_lock[s] != 0 || m_sticky[s] != 0)) ee = 1'b1;
                else if (w) m_bank[s][a] = d;
                else ed = m_bank[s][a];
            end else if (a == 'h40) begin
                if (full && w) begin
                    m_lock[s] = (d == KEY) ? 1 : 0;
                    if (d == KEY) m_ptr[s] = 0;
                end
            end else if (a == 'h41) begin
                if (full && !w) ed = 32'h1 | (m_lock[s] != 0 ? 32'h2 : 32'h0);
            end else if (a == 'h42) begin
                if (!full || m_lock[s] == 0) ee = 1'b1;
                else begin
                    if (w) begin
                        if (m_ptr[s] >= 1 && m_ptr[s] <= depth) m_bank[s][m_ptr[s]-1] = d;
                    end else begin
                        if (m_ptr[s] == 0) ed = depth;
                        else if (m_ptr[s] <= depth) ed = m_bank[s][m_ptr[s]-1];
                    end
                    if (m_ptr[s] < depth + 1) m_ptr[s]++;
                end
            end else if (a == 'h45) begin
                if (!w) begin
                    ed = (m_sticky[s] != 0) ? 32'h3 : 32'h1;
                    m_sticky[s] = 0;
                end
            end
        end
        if (ev && full) begin
            m_sticky[s] = 1;
            for (int i = 0; i < FD; i++) m_bank[s][i] = 32'hA000_0000 + i;
        end
    endtask

    // One bus cycle on instance s; compared against the model after the edge
    task automatic cycle(input string req, input int s, input bit v, input bit w,
                         input int a, input logic [31:0] d, input bit ev);
        bit ee;
        logic [31:0] ed;
        bit gv, ge, ov;
        logic [31:0] gd;
        vf = (s == 0) && v;
        vs = (s == 1) && v;
        wr = w;
        addr = 8'(a);
        wdata = d;
        evt_f = (s == 0) && ev;
        evt_s = (s == 1) && ev;
        model_step(s, v, w, a, d, ev, ee, ed);
        @(negedge clk);
        vf = 1'b0; vs = 1'b0; evt_f = 1'b0; evt_s = 1'b0;
        gv = (s == 0) ? f_v : s_v;
        ge = (s == 0) ? f_e : s_e;
        gd = (s == 0) ? f_d : s_d;
        ov = (s == 0) ? s_v : f_v;
        checks++;
        if (gv !== v || ov !== 1'b0 || (v && (ge !== ee || gd !== ed))) begin
            errors++;
            $display("FAIL %s: inst %0d addr %0h got v=%0b e=%0b d=%h other_v=%0b, exp v=%0b e=%0b d=%h other_v=0",
                     req, s, a, gv, ge, gd, ov, v, ee, ed);
        end
    endtask

    task automatic rd(input string req, input int s, input int a);
        cycle(req, s, 1'b1, 1'b0, a, 32'h0, 1'b0);
    endtask

    task automatic wrt(input string req, input int s, input int a, input logic [31:0] d);
        cycle(req, s, 1'b1, 1'b1, a, d, 1'b0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got hang, exp finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2 / R5 / R6: state out of reset
        rd("R2 lock status after reset", 0, 'h41);
        rd("R5 trace read blocked by sticky", 0, 0);
        rd("R6 power status shows sticky", 0, 'h45);
        rd("R6 power status after clear", 0, 'h45);
        for (int i = 0; i < FD; i++) rd("R1 bank default", 0, i);
        rd("R11 lock access read", 0, 'h40);

        // R12: idle cycle produces no response
        cycle("R12 idle cycle", 0, 1'b0, 1'b0, 0, 32'h0, 1'b0);

        // Open access
        wrt("R5 trace write allowed", 0, 1, 32'h1234_5678);
        rd("R5 trace readback", 0, 1);
        rd("R13 unmapped read", 0, 'h7F);

        // R10: save/restore refused while unlocked
        rd("R10 sr read unlocked", 0, 'h42);
        wrt("R10 sr write unlocked", 0, 'h42, 32'hDEAD_BEEF);
        rd("R10 bank untouched", 0, 0);

        // R4: wrong key leaves lock clear
        wrt("R4 wrong key", 0, 'h40, 32'h1111_2222);
        rd("R4 status after wrong key", 0, 'h41);

        // R8: save sequence
        rd("R6 clear sticky before save", 0, 'h45);
        wrt("R4 key sets lock", 0, 'h40, KEY);
        rd("R2 status shows lock", 0, 'h41);
        rd("R5 trace read blocked by lock", 0, 2);
        wrt("R5 trace write blocked by lock", 0, 2, 32'h5555_AAAA);
        for (int i = 0; i <= FD; i++) rd("R8 save stream", 0, 'h42);
        rd("R13 save overrun", 0, 'h42);
        rd("R13 save overrun again", 0, 'h42);

        // R7: power loss
        cycle("R7 power event alone", 0, 1'b0, 1'b0, 0, 32'h0, 1'b1);
        rd("R7 sticky after event", 0, 'h45);

        // R9: restore sequence (lock still set); rekey rewinds the pointer
        wrt("R8 rekey rewinds", 0, 'h40, KEY);
        wrt("R9 first write discarded", 0, 'h42, 32'hFFFF_0000);
        for (int i = 0; i < FD; i++) wrt("R9 restore stream", 0, 'h42, 32'h0BAD_0000 + i*3);
        wrt("R13 restore overrun", 0, 'h42, 32'h7777_7777);
        wrt("R4 release lock", 0, 'h40, 32'h0);
        for (int i = 0; i < FD; i++) rd("R9 restored value", 0, i);

        // R7: event wins against same-cycle status read and bank write
        cycle("R7 event with status read", 0, 1'b1, 1'b0, 'h45, 32'h0, 1'b1);
        rd("R7 sticky kept", 0, 'h45);
        cycle("R7 event with bank write", 0, 1'b1, 1'b1, 3, 32'h9999_9999, 1'b1);
        rd("R6 clear sticky", 0, 'h45);
        rd("R7 bank back to default", 0, 3);
        rd("R7 bank back to default", 0, 1);

        // R3: single-power variant
        rd("R3 single lock status", 1, 'h41);
        rd("R3 single power status", 1, 'h45);
        rd("R3 single power status repeat", 1, 'h45);
        rd("R3 single trace no error", 1, 2);
        wrt("R3 single key ignored", 1, 'h40, KEY);
        rd("R3 single status after key", 1, 'h41);
        wrt("R3 single trace write", 1, 0, 32'hCAFE_0001);
        rd("R3 single trace readback", 1, 0);
        rd("R3 single sr refused", 1, 'h42);
        cycle("R3 single event no effect", 1, 1'b1, 1'b0, 0, 32'h0, 1'b1);
        rd("R3 single power status after event", 1, 'h45);
        cycle("R12 idle single", 1, 1'b0, 1'b0, 0, 32'h0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule